// File: doc/BRIEF.md
# Hypercube Next-Hop Router

This block makes the forwarding decision for a single node of a binary cube network whose default dimension is three, which gives eight nodes. When a message arrives, the block combines its destination with the node's own address by exclusive-OR. Every bit set in the result marks an axis on which the two addresses still differ. The message leaves on the link for one of those axes. If the result is zero, the message is already at its destination and is handed to the local port.

The node address is an input, so the same block can be placed at every node. Link `i` connects to the neighbour whose address equals this node's address with bit `i` inverted. Whenever several axes differ, the lowest-numbered one is chosen. This makes the route fully deterministic. A message that passes through a chain of such routers therefore corrects its differing bits one at a time, from the least significant upward.

All outputs are registered, so each hop takes exactly one clock cycle. The destination and the payload pass through without change.

Top module: `hc_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every link valid and the local valid are low.
- R2: If an accepted message has a destination equal to `node_addr`, then in the next cycle `loc_valid` is high, `loc_dest` and `loc_data` equal the message's destination and payload, and no link valid is high.
- R3: If an accepted message has a destination that differs from `node_addr`, then in the next cycle only `link_valid[i]` is high, where `i` is the index of the lowest set bit of `node_addr ^ in_dest`. Bit 0 is the least significant bit.
- R4: A forwarded message appears on link `i` with its destination in `link_dest[i*DIM +: DIM]` and its payload in `link_data[i*PW +: PW]`, both unchanged.
- R5: Each accepted message produces exactly one valid output in the following cycle.
- R6: A cycle with `in_valid` low produces no valid output in the following cycle, whatever values the other inputs hold.
- R7: Link `i` leads to the node `node_addr ^ (1 << i)`. A message passed through successive routers reaches its destination after exactly popcount(source ^ destination) hops, for example three hops from 000 to 111, and each hop inverts exactly one address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_addr | input | DIM | Address of this node |
| in_valid | input | 1 | An arriving message is present |
| in_dest | input | DIM | Destination address of the arriving message |
| in_data | input | PW | Payload of the arriving message |
| link_valid | output | DIM | Valid for each outgoing axis link |
| link_dest | output | DIM*DIM | Destination for each link, packed with link i at [i*DIM +: DIM] |
| link_data | output | DIM*PW | Payload for each link, packed with link i at [i*PW +: PW] |
| loc_valid | output | 1 | A message is delivered to this node |
| loc_dest | output | DIM | Destination of the delivered message |
| loc_data | output | PW | Payload of the delivered message |

## Verification
The bench sweeps every pair of node address and destination, 64 in all, with a payload tied to each pair. The pairs whose exclusive-OR is zero check local delivery. The pairs with one, two or three differing bits check that the lowest set bit always wins over the higher ones. Idle cycles that hold a live destination on the inputs check that nothing is emitted without `in_valid`. For every source and destination, a chain of hops reuses the router by feeding each emitted neighbour back in as the node address. This confirms that each hop inverts exactly one bit and that the hop count equals the Hamming distance.

// File: rtl/hc_pkg.sv
// Package hc_pkg
// Holds the default sizes shared by the router and its sub-blocks.
// Assumes a binary cube in which every node carries an address of
// DEF_DIM bits and owns one link per axis.
package hc_pkg;
    localparam int DEF_DIM = 3;
    localparam int DEF_PW  = 16;
endpackage

// File: rtl/hc_axis_pick.sv
// Module hc_axis_pick
// Takes the difference vector (node XOR destination). Returns a one-hot
// vector that marks its lowest set bit, and a flag that is high when the
// vector is zero. Purely combinational.
// Assumes W >= 1.
module hc_axis_pick #(
    parameter int W = hc_pkg::DEF_DIM
) (
    input  logic [W-1:0] diff,
    output logic [W-1:0] sel,
    output logic         zero
);
    // seen[i] is high when any bit below position i is set
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_prefix
            // a bit wins only if no lower bit has won already
            assign sel[i]    = diff[i] & ~seen[i];
            assign seen[i+1] = seen[i] | diff[i];
        end
    endgenerate

    // zero difference means the message is home
    assign zero = ~seen[W];
endmodule

// File: rtl/hc_out_port.sv
// Module hc_out_port
// A single registered output port. When take is high, it captures the
// destination and payload and raises valid for one cycle. Without take,
// valid goes low and the captured fields hold their values.
// Assumes a synchronous, active-low reset.
module hc_out_port #(
    parameter int AW = hc_pkg::DEF_DIM,
    parameter int PW = hc_pkg::DEF_PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] dest_i,
    input  logic [PW-1:0] data_i,
    output logic          valid_o,
    output logic [AW-1:0] dest_o,
    output logic [PW-1:0] data_o
);
    // valid follows take with one cycle of delay
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= take;
    end

    // capture the message fields on the cycle the port is chosen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_o <= '0;
            data_o <= '0;
        end else if (take) begin
            dest_o <= dest_i;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/hc_router.sv
// Module hc_router
// Next-hop router for one node of a binary cube of dimension DIM. It
// forms node_addr XOR in_dest and sends the message out on the link of
// the lowest differing axis. When the two addresses match, it delivers
// the message to the local port instead. Every output is registered, so
// a hop costs one cycle. The node has no link-level flow control, so
// every message is accepted on the cycle it arrives.
module hc_router #(
    parameter int DIM = hc_pkg::DEF_DIM,
    parameter int PW  = hc_pkg::DEF_PW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIM-1:0]     node_addr,
    input  logic               in_valid,
    input  logic [DIM-1:0]     in_dest,
    input  logic [PW-1:0]      in_data,
    output logic [DIM-1:0]     link_valid,
    output logic [DIM*DIM-1:0] link_dest,
    output logic [DIM*PW-1:0]  link_data,
    output logic               loc_valid,
    output logic [DIM-1:0]     loc_dest,
    output logic [PW-1:0]      loc_data
);
    localparam int AW = DIM;

    logic [AW-1:0]  diff;
    logic [DIM-1:0] pick;
    logic           at_home;

    // one bit is set for every axis on which the addresses differ
    assign diff = node_addr ^ in_dest;

    hc_axis_pick #(.W(DIM)) u_pick (
        .diff (diff),
        .sel  (pick),
        .zero (at_home)
    );

    genvar g;
    generate
        for (g = 0; g < DIM; g++) begin : g_link
            // link g carries messages whose lowest differing axis is g
            hc_out_port #(.AW(AW), .PW(PW)) u_link (
                .clk     (clk),
                .rst_n   (rst_n),
                .take    (in_valid & pick[g]),
                .dest_i  (in_dest),
                .data_i  (in_data),
                .valid_o (link_valid[g]),
                .dest_o  (link_dest[g*AW +: AW]),
                .data_o  (link_data[g*PW +: PW])
            );
        end
    endgenerate

    // local delivery port for messages that have arrived
    hc_out_port #(.AW(AW), .PW(PW)) u_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (in_valid & at_home),
        .dest_i  (in_dest),
        .data_i  (in_data),
        .valid_o (loc_valid),
        .dest_o  (loc_dest),
        .data_o  (loc_data)
    );

    // R2: a message that has arrived goes to the local port with its payload
    a_r2_local_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dest == node_addr) |=>
            (loc_valid && link_valid == '0 && loc_data == $past(in_data)));

    // R3: the emitted link lies on an axis that actually differed
    a_r3_axis_differs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dest != node_addr) |=>
            (!loc_valid && (link_valid & ~$past(node_addr ^ in_dest)) == '0));

    // R5: an accepted message raises exactly one output
    a_r5_exactly_one: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($countones({link_valid, loc_valid}) == 1));

    // R6: no input means no output
    a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (link_valid == '0 && !loc_valid));

    // R5: the outputs are never valid on more than one port at once
    a_r5_onehot_out: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_valid, loc_valid}));
endmodule

// File: tb/hc_router_tb.sv
module hc_router_tb;
    localparam int DIM = 3;
    localparam int PW  = 16;
    localparam int N   = 1 << DIM;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [DIM-1:0]     node_addr;
    logic               in_valid;
    logic [DIM-1:0]     in_dest;
    logic [PW-1:0]      in_data;
    logic [DIM-1:0]     link_valid;
    logic [DIM*DIM-1:0] link_dest;
    logic [DIM*PW-1:0]  link_data;
    logic               loc_valid;
    logic [DIM-1:0]     loc_dest;
    logic [PW-1:0]      loc_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    hc_router #(.DIM(DIM), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .in_valid(in_valid),
        .in_dest(in_dest), .in_data(in_data), .link_valid(link_valid),
        .link_dest(link_dest), .link_data(link_data), .loc_valid(loc_valid),
        .loc_dest(loc_dest), .loc_data(loc_data)
    );

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // present one message, then look at the outputs one cycle later
    task automatic hop(input logic [DIM-1:0] nd, input logic [DIM-1:0] ds,
                       input logic [PW-1:0] pl);
        node_addr = nd; in_dest = ds; in_data = pl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; node_addr = '0; in_valid = 1'b0; in_dest = '0; in_data = '0;
        repeat (3) @(negedge clk);
        check({link_valid, loc_valid} == '0, "R1 in reset", {link_valid, loc_valid}, 0);
        in_valid = 1'b1; in_dest = 3'b101;  // ignored while reset is held
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check({link_valid, loc_valid} == '0, "R1 after release", {link_valid, loc_valid}, 0);

        // exhaustive sweep over every node and destination
        for (int nd = 0; nd < N; nd++) begin
            for (int ds = 0; ds < N; ds++) begin
                logic [DIM-1:0] d, low;
                logic [PW-1:0]  pl;
                pl  = PW'(16'hA500 + nd * 16 + ds);
                d   = DIM'(nd ^ ds);
                low = d & (~d + 1'b1);
                hop(DIM'(nd), DIM'(ds), pl);
                check($countones({link_valid, loc_valid}) == 1, "R5 one output",
                      {link_valid, loc_valid}, 1);
                if (d == 0) begin
                    check(loc_valid && link_valid == 0 && loc_dest == DIM'(ds)
                          && loc_data == pl, "R2 local delivery",
                          {loc_valid, link_valid, loc_data}, {1'b1, 3'b0, pl});
                end else begin
                    check(link_valid == low && !loc_valid, "R3 lowest axis",
                          link_valid, low);
                    for (int i = 0; i < DIM; i++) begin
                        if (low[i])
                            check(link_dest[i*DIM +: DIM] == DIM'(ds)
                                  && link_data[i*PW +: PW] == pl, "R4 fields unchanged",
                                  {link_dest[i*DIM +: DIM], link_data[i*PW +: PW]},
                                  {DIM'(ds), pl});
                    end
                end
                // idle cycle with live-looking inputs
                in_dest = DIM'(~ds);
                @(negedge clk);
                check({link_valid, loc_valid} == '0, "R6 idle no output",
                      {link_valid, loc_valid}, 0);
            end
        end

        // chained hops for every source and destination
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                logic [DIM-1:0] cur;
                int hops;
                bit done, good;
                cur = DIM'(s); hops = 0; done = 0; good = 1;
                for (int k = 0; k <= DIM && !done; k++) begin
                    hop(cur, DIM'(t), 16'h5A5A);
                    if (loc_valid) begin
                        done = 1;
                        if (cur != DIM'(t)) good = 0;
                    end else if ($countones(link_valid) == 1) begin
                        cur = cur ^ link_valid;   // neighbour across that axis
                        hops++;
                    end else begin
                        good = 0; done = 1;
                    end
                end
                check(good && done && hops == $countones(s ^ t), "R7 chain hop count",
                      hops, $countones(s ^ t));
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule